// File: doc/BRIEF.md
# Banked Memory and Video Plane Mapper

This block sits between an 8-bit CPU with a 64 KiB address space and the memories around it. Two bank-control registers are written by the CPU through I/O ports. For every memory request, the block uses those registers to choose one destination: internal ROM, a small disk boot ROM, main RAM, or one or more video planes. It then drives the matching chip selects, write enables and local addresses, all registered one cycle after the request.

The lower 32 KiB window can be switched between ROM and RAM. The 16 KiB window above it can be switched between RAM and video memory. The top 16 KiB is always RAM. A separate overlay register places the boot ROM over a 4 KiB slice of the lower window, and the overlay wins over the ROM/RAM choice.

When the middle window shows video memory, four active-low plane-select bits pick any set of planes (blue, green, red, text). A single CPU write then reaches all selected planes at once. A read is answered by the lowest-numbered selected plane only.

Top module: `vram_bank_mapper`

## Requirements
- R1: After reset, the bank register reads 0x0F and the overlay register reads 0x00. A read of 0x0000 selects internal ROM. Reset also restores these values when it is applied mid-run.
- R2: For 0x0000–0x7FFF, bank bit 5 = 0 selects ROM (reads only), and bank bit 5 = 1 selects RAM for reads and writes.
- R3: For 0x8000–0xBFFF, bank bit 4 = 0 selects RAM, and bank bit 4 = 1 selects video memory.
- R4: 0xC000–0xFFFF always selects RAM, whatever both registers hold.
- R5: Bank bits 0, 1, 2 and 3 are active-low selects for planes 0 (blue), 1 (green), 2 (red) and 3 (text); bit i drives plane_cs[i]. With all four bits at 1, no plane and no RAM is selected.
- R6: While bank bit 4 = 0, the plane-select bits have no effect: plane_cs and plane_we stay 0, and the middle window goes to RAM.
- R7: A video write asserts plane_cs and plane_we for every plane whose select bit is 0, in the same cycle.
- R8: A video read asserts plane_cs only for the lowest-numbered selected plane.
- R9: With overlay bit 0 = 1, reads of 0x6000–0x6FFF select the boot ROM whatever bank bit 5 holds. 0x5FFF and 0x7000 are unaffected, and with the overlay off 0x6000 follows bank bit 5.
- R10: An I/O read returns, one cycle later, the last value written to the bank port (all 8 bits), the overlay bit in bit 0 of the overlay port with the other bits 0, or 0 for any other port. A write to any other port changes neither register.
- R11: A write that decodes to ROM or boot ROM asserts no chip select and no write enable.
- R12: Outputs change one cycle after the request. With no request, all chip selects and write enables are 0. Each local address is a slice of the CPU address: ram_addr = full address, rom_addr = bits 14:0, bootrom_addr = bits 11:0, plane_addr = bits 13:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data, valid the cycle after io_rd |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| rom_cs | output | 1 | Internal ROM select |
| bootrom_cs | output | 1 | Boot ROM select |
| ram_cs | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| plane_cs | output | 4 | Video plane selects (0 blue, 1 green, 2 red, 3 text) |
| plane_we | output | 4 | Video plane write enables |
| ram_addr | output | 16 | RAM address |
| rom_addr | output | 15 | Internal ROM address |
| bootrom_addr | output | 12 | Boot ROM address |
| plane_addr | output | 14 | Video plane address |

## Verification
Each register write on an I/O port takes effect at the clock edge that samples it, so a memory request made in any later cycle is decoded with the new value. All memory-side outputs appear after exactly one edge. The I/O read data also appears one edge after io_rd. The bench therefore raises each request half a cycle before an edge, compares all outputs half a cycle after that edge, and drops the request at that same point. An idle cycle after a request confirms that the outputs clear again one edge later.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ROM,
    TGT_BOOT,
    TGT_RAM,
    TGT_VIDEO
  } target_e;

  localparam int LOWRAM_BIT = 5;
  localparam int VIDEO_BIT  = 4;

endpackage

// File: rtl/bank_regs.sv
module bank_regs #(
  parameter int IO_W = 8,
  parameter int DATA_W = 8,
  parameter logic [IO_W-1:0] PORT_BANK = 'h10,
  parameter logic [IO_W-1:0] PORT_BOOT = 'h11,
  parameter logic [DATA_W-1:0] BANK_RST = 'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_W-1:0]   io_port,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] bank_q,
  output logic              boot_q
);

  logic              hit_bank;
  logic              hit_boot;
  logic [DATA_W-1:0] rd_mux;

  assign hit_bank = (io_port == PORT_BANK);
  assign hit_boot = (io_port == PORT_BOOT);

  always_comb begin
    rd_mux = '0;
    if (hit_bank)      rd_mux = bank_q;
    else if (hit_boot) rd_mux = {{(DATA_W-1){1'b0}}, boot_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q   <= BANK_RST;
      boot_q   <= 1'b0;
      io_rdata <= '0;
    end else begin
      if (io_wr && hit_bank) bank_q <= io_wdata;
      if (io_wr && hit_boot) boot_q <= io_wdata[0];
      io_rdata <= io_rd ? rd_mux : '0;
    end
  end

  AST_RESET_BOOTS_ROM: assert property (@(posedge clk)
    rst |=> (bank_q[mapper_pkg::LOWRAM_BIT] == 1'b0 &&
             bank_q[mapper_pkg::VIDEO_BIT] == 1'b0 && !boot_q)); // R1

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && hit_bank) |=> $stable(bank_q)); // R10

  AST_BANK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (io_rd && hit_bank) |=> io_rdata == $past(bank_q)); // R10

endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [3:0] BOOT_TAG = 4'h6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              low_ram,
  input  logic              mid_video,
  input  logic              boot_on,
  output target_e           tgt
);

  localparam int TAG_LSB = ADDR_W - 4;

  always_comb begin
    tgt = TGT_RAM;
    if (!addr[ADDR_W-1]) begin
      if (boot_on && addr[ADDR_W-1:TAG_LSB] == BOOT_TAG) tgt = TGT_BOOT;
      else if (low_ram)                                  tgt = TGT_RAM;
      else                                               tgt = TGT_ROM;
    end else if (!addr[ADDR_W-2]) begin
      tgt = mid_video ? TGT_VIDEO : TGT_RAM;
    end
  end

endmodule

// File: rtl/plane_strobe.sv
module plane_strobe #(
  parameter int NPLANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               is_wr,
  input  logic [NPLANES-1:0] sel_n,
  output logic [NPLANES-1:0] cs,
  output logic [NPLANES-1:0] we
);

  logic [NPLANES-1:0] sel;
  logic [NPLANES:0]   seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NPLANES; i++) begin : g_plane
    assign sel[i]    = en & ~sel_n[i];
    assign seen[i+1] = seen[i] | sel[i];
    assign cs[i]     = is_wr ? sel[i] : (sel[i] & ~seen[i]);
    assign we[i]     = is_wr & sel[i];
  end

  AST_READ_SINGLE_PLANE: assert property (@(posedge clk) disable iff (rst)
    !is_wr |-> $onehot0(cs)); // R8

  AST_WRITE_REACHES_ALL: assert property (@(posedge clk) disable iff (rst)
    (en && is_wr) |-> we == ~sel_n); // R7

endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IO_W = 8,
  parameter int NPLANES = 4,
  parameter logic [IO_W-1:0] PORT_BANK = 'h10,
  parameter logic [IO_W-1:0] PORT_BOOT = 'h11,
  parameter logic [3:0] BOOT_TAG = 4'h6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IO_W-1:0]    io_port,
  input  logic [DATA_W-1:0]  io_wdata,
  input  logic               io_wr,
  input  logic               io_rd,
  output logic [DATA_W-1:0]  io_rdata,
  input  logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rd,
  input  logic               mem_wr,
  output logic               rom_cs,
  output logic               bootrom_cs,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [NPLANES-1:0] plane_cs,
  output logic [NPLANES-1:0] plane_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [ADDR_W-2:0]  rom_addr,
  output logic [ADDR_W-5:0]  bootrom_addr,
  output logic [ADDR_W-3:0]  plane_addr
);

  localparam logic [DATA_W-1:0] BANK_RST = DATA_W'((1 << NPLANES) - 1);

  logic [DATA_W-1:0]  bank_q;
  logic               boot_q;
  target_e            tgt;
  logic               req;
  logic               rd_only;
  logic [NPLANES-1:0] pcs_d;
  logic [NPLANES-1:0] pwe_d;

  assign req     = mem_rd | mem_wr;
  assign rd_only = mem_rd & ~mem_wr;

  bank_regs #(
    .IO_W(IO_W), .DATA_W(DATA_W),
    .PORT_BANK(PORT_BANK), .PORT_BOOT(PORT_BOOT), .BANK_RST(BANK_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .io_port(io_port), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .bank_q(bank_q), .boot_q(boot_q)
  );

  addr_decode #(.ADDR_W(ADDR_W), .BOOT_TAG(BOOT_TAG)) u_dec (
    .addr(mem_addr), .low_ram(bank_q[LOWRAM_BIT]),
    .mid_video(bank_q[VIDEO_BIT]), .boot_on(boot_q), .tgt(tgt)
  );

  plane_strobe #(.NPLANES(NPLANES)) u_planes (
    .clk(clk), .rst(rst), .en(req && tgt == TGT_VIDEO), .is_wr(mem_wr),
    .sel_n(bank_q[NPLANES-1:0]), .cs(pcs_d), .we(pwe_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs       <= 1'b0;
      bootrom_cs   <= 1'b0;
      ram_cs       <= 1'b0;
      ram_we       <= 1'b0;
      plane_cs     <= '0;
      plane_we     <= '0;
      ram_addr     <= '0;
      rom_addr     <= '0;
      bootrom_addr <= '0;
      plane_addr   <= '0;
    end else begin
      rom_cs       <= rd_only && tgt == TGT_ROM;
      bootrom_cs   <= rd_only && tgt == TGT_BOOT;
      ram_cs       <= req && tgt == TGT_RAM;
      ram_we       <= mem_wr && tgt == TGT_RAM;
      plane_cs     <= pcs_d;
      plane_we     <= pwe_d;
      ram_addr     <= mem_addr;
      rom_addr     <= mem_addr[ADDR_W-2:0];
      bootrom_addr <= mem_addr[ADDR_W-5:0];
      plane_addr   <= mem_addr[ADDR_W-3:0];
    end
  end

  AST_ONE_DESTINATION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, bootrom_cs, ram_cs, |plane_cs})); // R12

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rom_cs || bootrom_cs) |-> (!ram_we && plane_we == '0)); // R11

  AST_TOP_WINDOW_RAM: assert property (@(posedge clk) disable iff (rst)
    (req && mem_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |=> ram_cs); // R4

  AST_PLANES_IDLE_IN_RAM_MODE: assert property (@(posedge clk) disable iff (rst)
    (req && mem_addr[ADDR_W-1:ADDR_W-2] == 2'b10 && !bank_q[VIDEO_BIT])
      |=> (plane_cs == '0 && ram_cs)); // R6

  AST_WE_WITHIN_CS: assert property (@(posedge clk) disable iff (rst)
    (plane_we & ~plane_cs) == '0); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!rom_cs && !bootrom_cs && !ram_cs && !ram_we &&
              plane_cs == '0 && plane_we == '0)); // R12

endmodule

// File: tb/vram_bank_mapper_tb.sv
module vram_bank_mapper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;
  localparam logic [7:0] P_BANK = 8'h10;
  localparam logic [7:0] P_BOOT = 8'h11;
  localparam int NVEC = 25;

  // [41:34] bank, [33] overlay, [32] write, [31:16] address,
  // [15:12] {rom, boot, ram, ram_we}, [11:8] plane_cs, [7:4] plane_we, [3:0] req
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h0F, 1'b0, 1'b0, 16'h1234, 4'b1000, 4'h0, 4'h0, 4'd2},  // R2
    {8'h20, 1'b0, 1'b0, 16'h1234, 4'b0010, 4'h0, 4'h0, 4'd2},  // R2
    {8'h20, 1'b0, 1'b1, 16'h7FFF, 4'b0011, 4'h0, 4'h0, 4'd2},  // R2
    {8'h0F, 1'b0, 1'b1, 16'h0100, 4'b0000, 4'h0, 4'h0, 4'd11}, // R11
    {8'h00, 1'b0, 1'b0, 16'h8000, 4'b0010, 4'h0, 4'h0, 4'd6},  // R6
    {8'h00, 1'b0, 1'b1, 16'hA000, 4'b0011, 4'h0, 4'h0, 4'd6},  // R6
    {8'h1E, 1'b0, 1'b0, 16'h9000, 4'b0000, 4'h1, 4'h0, 4'd5},  // R5 R3
    {8'h1D, 1'b0, 1'b0, 16'hA000, 4'b0000, 4'h2, 4'h0, 4'd5},  // R5
    {8'h1B, 1'b0, 1'b0, 16'hA000, 4'b0000, 4'h4, 4'h0, 4'd5},  // R5
    {8'h17, 1'b0, 1'b0, 16'hBFFF, 4'b0000, 4'h8, 4'h0, 4'd5},  // R5
    {8'h1F, 1'b0, 1'b0, 16'h8000, 4'b0000, 4'h0, 4'h0, 4'd5},  // R5
    {8'h10, 1'b0, 1'b1, 16'h8001, 4'b0000, 4'hF, 4'hF, 4'd7},  // R7
    {8'h1A, 1'b0, 1'b1, 16'h8002, 4'b0000, 4'h5, 4'h5, 4'd7},  // R7
    {8'h19, 1'b0, 1'b0, 16'h8003, 4'b0000, 4'h2, 4'h0, 4'd8},  // R8
    {8'h13, 1'b0, 1'b0, 16'h8003, 4'b0000, 4'h4, 4'h0, 4'd8},  // R8
    {8'h10, 1'b0, 1'b0, 16'h8003, 4'b0000, 4'h1, 4'h0, 4'd8},  // R8
    {8'h10, 1'b0, 1'b0, 16'hC000, 4'b0010, 4'h0, 4'h0, 4'd4},  // R4
    {8'h1F, 1'b1, 1'b1, 16'hFFFF, 4'b0011, 4'h0, 4'h0, 4'd4},  // R4
    {8'h0F, 1'b1, 1'b0, 16'h6000, 4'b0100, 4'h0, 4'h0, 4'd9},  // R9
    {8'h2F, 1'b1, 1'b0, 16'h6FFF, 4'b0100, 4'h0, 4'h0, 4'd9},  // R9
    {8'h2F, 1'b1, 1'b1, 16'h6800, 4'b0000, 4'h0, 4'h0, 4'd11}, // R11
    {8'h0F, 1'b1, 1'b0, 16'h5FFF, 4'b1000, 4'h0, 4'h0, 4'd9},  // R9
    {8'h2F, 1'b1, 1'b0, 16'h7000, 4'b0010, 4'h0, 4'h0, 4'd9},  // R9
    {8'h0F, 1'b0, 1'b0, 16'h6000, 4'b1000, 4'h0, 4'h0, 4'd9},  // R9
    {8'h3E, 1'b1, 1'b1, 16'h4000, 4'b0011, 4'h0, 4'h0, 4'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_port = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [15:0] mem_addr = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        rom_cs, bootrom_cs, ram_cs, ram_we;
  logic [3:0]  plane_cs, plane_we;
  logic [15:0] ram_addr;
  logic [14:0] rom_addr;
  logic [11:0] bootrom_addr;
  logic [13:0] plane_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_bank_mapper #(.PORT_BANK(P_BANK), .PORT_BOOT(P_BOOT)) dut_i (
    .clk(clk), .rst(rst), .io_port(io_port), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rom_cs(rom_cs), .bootrom_cs(bootrom_cs), .ram_cs(ram_cs), .ram_we(ram_we),
    .plane_cs(plane_cs), .plane_we(plane_we), .ram_addr(ram_addr),
    .rom_addr(rom_addr), .bootrom_addr(bootrom_addr), .plane_addr(plane_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    io_port = port; io_wdata = data; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] port, output logic [7:0] data);
    @(negedge clk);
    io_port = port; io_rd = 1'b1;
    @(negedge clk);
    data = io_rdata;
    io_rd = 1'b0;
  endtask

  // request raised at a negedge; outputs compared one edge later
  task automatic mem_access(input logic wr, input logic [15:0] addr);
    @(negedge clk);
    mem_addr = addr; mem_wr = wr; mem_rd = ~wr;
    @(negedge clk);
  endtask

  task automatic mem_idle();
    mem_rd = 1'b0; mem_wr = 1'b0;
  endtask

  function automatic logic [11:0] outs();
    return {rom_cs, bootrom_cs, ram_cs, ram_we, plane_cs, plane_we};
  endfunction

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    io_read(P_BANK, rd);
    check("R1 bank reset", 32'(rd), 32'h0F);
    io_read(P_BOOT, rd);
    check("R1 overlay reset", 32'(rd), 32'h00);
    mem_access(1'b0, 16'h0000);
    check("R1 boot from rom", 32'(outs()), 32'h800);
    mem_idle();

    // R12 idle cycle clears everything
    @(negedge clk);
    check("R12 idle outputs", 32'(outs()), 32'h000);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      io_write(P_BANK, VEC[i][41:34]);
      io_write(P_BOOT, {7'b0, VEC[i][33]});
      mem_access(VEC[i][32], VEC[i][31:16]);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            32'(outs()), 32'(VEC[i][15:4]));
      mem_idle();
    end

    // R12 local address slices
    io_write(P_BANK, 8'h1E);
    io_write(P_BOOT, 8'h01);
    mem_access(1'b0, 16'h9ABC);
    check("R12 plane_addr", 32'(plane_addr), 32'h1ABC);
    mem_access(1'b1, 16'hD123);
    check("R12 ram_addr", 32'(ram_addr), 32'hD123);
    mem_access(1'b0, 16'h6ABC);
    check("R12 bootrom_addr", 32'(bootrom_addr), 32'h0ABC);
    mem_access(1'b0, 16'h3456);
    check("R12 rom_addr", 32'(rom_addr), 32'h3456);
    mem_idle();

    // R10 readback
    io_write(P_BANK, 8'hA5);
    io_read(P_BANK, rd);
    check("R10 bank readback", 32'(rd), 32'hA5);
    io_write(P_BOOT, 8'hFE);
    io_read(P_BOOT, rd);
    check("R10 overlay bit0 clear", 32'(rd), 32'h00);
    io_write(P_BOOT, 8'hFF);
    io_read(P_BOOT, rd);
    check("R10 overlay bit0 set", 32'(rd), 32'h01);
    io_read(8'h42, rd);
    check("R10 other port reads zero", 32'(rd), 32'h00);
    io_write(8'h42, 8'h00);
    io_read(P_BANK, rd);
    check("R10 other port write ignored", 32'(rd), 32'hA5);

    // R1 reset mid-run
    io_write(P_BANK, 8'h30);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    io_read(P_BANK, rd);
    check("R1 bank after reset", 32'(rd), 32'h0F);
    io_read(P_BOOT, rd);
    check("R1 overlay after reset", 32'(rd), 32'h00);
    mem_access(1'b0, 16'h6000);
    check("R1 rom after reset", 32'(outs()), 32'h800);
    mem_idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule